// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a compact single-cycle processor with a 10-bit datapath. Its architectural state is an address register, a data register and a 6-bit program counter. It fetches 16-bit instruction words from a 64-entry program store and works on a 4-word data memory. Every rising edge retires exactly one instruction. An instruction either loads a constant into the address register or performs a compute step. A compute step feeds the data register and a second operand to an arithmetic unit, can write the result to any mix of destinations, and can branch on the sign of the result.

The program store is filled through a simple write port, normally while the core is held in reset. The address register has three jobs: it addresses the data memory, it is the second ALU operand when the memory operand is not selected, and it is the branch target. Debug outputs show the program counter, the address register and the data register at all times.

Instruction layout: if bit 15 is 0 the word is a constant load. If bit 15 is 1 it is a compute word with these fields: bit 12 is the operand select; bits 11:10 are reserved; bits 9:6 are the ALU function; bit 5 writes the address register; bit 4 writes the data register; bit 3 writes memory; bit 2 branches if negative; bit 1 branches if zero; bit 0 branches if positive.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted, the program counter, the address register, the data register and all four data-memory words are held at zero.
- R2: A word with bit 15 = 0 loads bits 9:0 into the address register, with bits 14:10 ignored. It leaves the data register and memory unchanged and advances the program counter by one.
- R3: In a compute word, bits 9:6 select the function of X (the data register) and Y (the second operand): 0→0, 1→1, 2→−1, 3→X, 4→Y, 5→~X, 6→~Y, 7→−X, 8→−Y, 9→X+1, 10→Y+1, 11→X−1, 12→Y−1, 13→X+Y, 14→X−Y, 15→Y−X. All results are taken modulo 2^10.
- R4: Bit 12 = 0 makes Y the address register. Bit 12 = 1 makes Y the data-memory word addressed by bits 1:0 of the address register.
- R5: Bit 5 writes the result to the address register, bit 4 writes it to the data register, and bit 3 writes it to the memory word addressed by the old address register. Any combination is allowed. A destination whose bit is clear keeps its value.
- R6: A compute word branches when an enabled condition holds on the 10-bit two's-complement result: bit 2 for negative, bit 1 for zero, bit 0 for positive. A taken branch loads bits 5:0 of the old address register into the program counter. Otherwise the counter increments and wraps from 63 to 0.
- R7: A memory read sees the value stored before the current edge. A read-modify-write of one word therefore completes within one instruction.
- R8: In a compute word, bits 14:13 and bits 11:10 have no effect.
- R9: A program-store write stores the data word at the given address on the rising edge. Later fetches from that address return the new word.
- R10: After reset is released, the first instruction retires on the third rising clock edge. The program counter stays 0 after the first two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| prog_we | input | 1 | Program-store write enable |
| prog_addr | input | 6 | Program-store write address |
| prog_wdata | input | 16 | Program-store write data |
| dbg_pc | output | 6 | Current program counter |
| dbg_a | output | 10 | Current address register |
| dbg_d | output | 10 | Current data register |

## Verification
The bench targets the following corner cases:
- Read-modify-write of one memory word. A memory with a registered read would return stale or doubled increments.
- A write to all three destinations at once. A design that updates the address register before using it would write memory at the wrong word or branch to the new value.
- Branch conditions at exactly zero, at −1 and at a positive value. A confused sign or zero test would take the wrong path.
- Program-counter wrap from 63 to 0, and reserved instruction bits set to ones. Either would send a careless decoder astray.
- Random programs compared step by step against a reference model, to catch any remaining decode or ALU slip.
- The release latency of reset, and reloading the program store between runs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int INSTR_W = 16;

  // instruction field positions (decoded by acc_cpu_decode)
  localparam int KIND_BIT = 15;
  localparam int OPSEL_BIT = 12;
  localparam int FN_HI = 9;
  localparam int FN_LO = 6;
  localparam int WRA_BIT = 5;
  localparam int WRD_BIT = 4;
  localparam int WRM_BIT = 3;

  typedef enum logic [3:0] {
    FN_ZERO  = 4'd0,
    FN_ONE   = 4'd1,
    FN_MONE  = 4'd2,
    FN_X     = 4'd3,
    FN_Y     = 4'd4,
    FN_NOTX  = 4'd5,
    FN_NOTY  = 4'd6,
    FN_NEGX  = 4'd7,
    FN_NEGY  = 4'd8,
    FN_XINC  = 4'd9,
    FN_YINC  = 4'd10,
    FN_XDEC  = 4'd11,
    FN_YDEC  = 4'd12,
    FN_ADD   = 4'd13,
    FN_XSUBY = 4'd14,
    FN_YSUBX = 4'd15
  } alu_fn_e;

  typedef struct packed {
    logic      is_comp;
    logic      use_mem;
    alu_fn_e   fn;
    logic      wr_a;
    logic      wr_d;
    logic      wr_m;
    logic [2:0] cond;   // {neg, zero, pos}
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/acc_cpu_imem.sv
module acc_cpu_imem #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/acc_cpu_dmem.sv
module acc_cpu_dmem #(
  parameter int WORD_W = 10,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [DEPTH-1:0][WORD_W-1:0] word_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic wen;
    assign wen = we && (addr == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[gi] <= '0;
      end else if (wen) begin
        word_q[gi] <= wdata;
      end
    end
  end

  // combinational read: sees contents before the coming edge (R7)
  assign rdata = word_q[addr];

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word_q[$past(addr)] == $past(wdata)));

  a_r5_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word_q));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (word_q == '0));
endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [INSTR_W-1:0] iw,
  output ctrl_t              ctrl
);
  logic       comp;
  logic [3:0] iw_unused;

  assign comp      = iw[KIND_BIT];
  assign iw_unused = {iw[14:13], iw[11:10]};   // reserved fields (R8)

  always_comb begin
    ctrl.is_comp = comp;
    ctrl.use_mem = comp & iw[OPSEL_BIT];
    ctrl.fn      = alu_fn_e'(iw[FN_HI:FN_LO]);
    ctrl.wr_a    = comp & iw[WRA_BIT];
    ctrl.wr_d    = comp & iw[WRD_BIT];
    ctrl.wr_m    = comp & iw[WRM_BIT];
    ctrl.cond    = comp ? iw[2:0] : 3'b000;
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 10
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (fn)
      FN_ZERO:  res = '0;
      FN_ONE:   res = ONE;
      FN_MONE:  res = '1;
      FN_X:     res = x;
      FN_Y:     res = y;
      FN_NOTX:  res = ~x;
      FN_NOTY:  res = ~y;
      FN_NEGX:  res = '0 - x;
      FN_NEGY:  res = '0 - y;
      FN_XINC:  res = x + ONE;
      FN_YINC:  res = y + ONE;
      FN_XDEC:  res = x - ONE;
      FN_YDEC:  res = y - ONE;
      FN_ADD:   res = x + y;
      FN_XSUBY: res = x - y;
      FN_YSUBX: res = y - x;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch #(
  parameter int W = 10
) (
  input  logic [W-1:0] res,
  input  logic [2:0]   cond,
  output logic         take
);
  logic neg, zero, pos;

  always_comb begin
    neg  = res[W-1];
    zero = (res == '0);
    pos  = !neg && !zero;
    take = |(cond & {neg, zero, pos});
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 4,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int DA_W      = $clog2(DMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_wdata,
  output logic [PC_W-1:0]    dbg_pc,
  output logic [DATA_W-1:0]  dbg_a,
  output logic [DATA_W-1:0]  dbg_d
);
  logic               core_rst_n;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic [DATA_W-1:0]  a_q, a_d, d_q, d_d;
  logic               a_en, d_en;
  logic [INSTR_W-1:0] instr_w;
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  mem_rd, opnd_y, alu_res;
  logic               take;

  acc_cpu_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  acc_cpu_imem #(.WORD_W(INSTR_W), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_wdata),
    .raddr (pc_q),
    .rdata (instr_w)
  );

  acc_cpu_decode u_dec (
    .iw   (instr_w),
    .ctrl (ctrl)
  );

  acc_cpu_dmem #(.WORD_W(DATA_W), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (ctrl.wr_m),
    .addr  (a_q[DA_W-1:0]),
    .wdata (alu_res),
    .rdata (mem_rd)
  );

  assign opnd_y = ctrl.use_mem ? mem_rd : a_q;

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .fn  (ctrl.fn),
    .x   (d_q),
    .y   (opnd_y),
    .res (alu_res)
  );

  acc_cpu_branch #(.W(DATA_W)) u_br (
    .res  (alu_res),
    .cond (ctrl.cond),
    .take (take)
  );

  // next-state logic
  always_comb begin
    pc_d = take ? a_q[PC_W-1:0] : pc_q + PC_W'(1);
    a_en = !ctrl.is_comp || ctrl.wr_a;
    a_d  = ctrl.is_comp ? alu_res : instr_w[DATA_W-1:0];
    d_en = ctrl.wr_d;
    d_d  = alu_res;
  end

  // state registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      pc_q <= pc_d;
      if (a_en) a_q <= a_d;
      if (d_en) d_q <= d_d;
    end
  end

  assign dbg_pc = pc_q;
  assign dbg_a  = a_q;
  assign dbg_d  = d_q;

  a_r1_reset_state: assert property (@(posedge clk)
    !core_rst_n |-> (pc_q == '0 && a_q == '0 && d_q == '0));

  a_r2_const_to_a: assert property (@(posedge clk) disable iff (!core_rst_n)
    !instr_w[KIND_BIT] |=> (a_q == $past(instr_w[DATA_W-1:0])));

  a_r2_const_keeps_d: assert property (@(posedge clk) disable iff (!core_rst_n)
    !instr_w[KIND_BIT] |=> $stable(d_q));

  a_r5_d_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(instr_w[KIND_BIT] && instr_w[WRD_BIT]) |=> $stable(d_q));

  a_r6_pc_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    !take |=> (pc_q == $past(pc_q) + PC_W'(1)));

  a_r6_pc_jump: assert property (@(posedge clk) disable iff (!core_rst_n)
    take |=> (pc_q == $past(a_q[PC_W-1:0])));

  a_r6_const_never_jumps: assert property (@(posedge clk) disable iff (!core_rst_n)
    !instr_w[KIND_BIT] |-> !take);
endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic        prog_we;
  logic [5:0]  prog_addr;
  logic [15:0] prog_wdata;
  logic [5:0]  dbg_pc;
  logic [9:0]  dbg_a, dbg_d;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] prog [64];
  logic [5:0]  m_pc;
  logic [9:0]  m_a, m_d;
  logic [9:0]  m_mem [4];

  acc_cpu_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_wdata (prog_wdata),
    .dbg_pc     (dbg_pc),
    .dbg_a      (dbg_a),
    .dbg_d      (dbg_d)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic logic [15:0] kc(input logic [9:0] v);
    return {6'b000000, v};
  endfunction

  function automatic logic [15:0] ci(input logic a, input logic [3:0] fn,
                                     input logic [2:0] dst, input logic [2:0] j);
    return {3'b111, a, 2'b00, fn, dst, j};
  endfunction

  function automatic logic [9:0] ref_alu(input logic [3:0] fn, input logic [9:0] x,
                                         input logic [9:0] y);
    case (fn)
      4'd0:  return 10'd0;
      4'd1:  return 10'd1;
      4'd2:  return 10'h3FF;
      4'd3:  return x;
      4'd4:  return y;
      4'd5:  return ~x;
      4'd6:  return ~y;
      4'd7:  return 10'd0 - x;
      4'd8:  return 10'd0 - y;
      4'd9:  return x + 10'd1;
      4'd10: return y + 10'd1;
      4'd11: return x - 10'd1;
      4'd12: return y - 10'd1;
      4'd13: return x + y;
      4'd14: return x - y;
      default: return y - x;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [15:0] iw;
    logic [9:0]  y, r;
    logic        tk;
    iw = prog[m_pc];
    if (!iw[15]) begin
      m_a  = iw[9:0];
      m_pc = m_pc + 6'd1;
    end else begin
      y  = iw[12] ? m_mem[m_a[1:0]] : m_a;
      r  = ref_alu(iw[9:6], m_d, y);
      tk = (iw[2] && r[9]) || (iw[1] && r == 10'd0) || (iw[0] && !r[9] && r != 10'd0);
      if (iw[3]) m_mem[m_a[1:0]] = r;
      m_pc = tk ? m_a[5:0] : m_pc + 6'd1;
      if (iw[5]) m_a = r;
      if (iw[4]) m_d = r;
    end
  endtask

  task automatic fill_nop();
    for (int i = 0; i < 64; i++) prog[i] = 16'hE000;
  endtask

  // preload under reset, then release and check reset latency (R1, R10)
  task automatic load_and_start();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", dbg_pc, 0);
    check("R1", "a in reset", dbg_a, 0);
    check("R1", "d in reset", dbg_d, 0);
    for (int i = 0; i < 64; i++) begin
      prog_we    = 1'b1;
      prog_addr  = 6'(i);
      prog_wdata = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    m_pc = '0; m_a = '0; m_d = '0;
    for (int i = 0; i < 4; i++) m_mem[i] = '0;
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R10", "pc two edges after release", dbg_pc, 0);
    check("R10", "a two edges after release", dbg_a, 0);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(negedge clk);
      check(tag, "pc", dbg_pc, m_pc);
      check(tag, "a", dbg_a, m_a);
      check(tag, "d", dbg_d, m_d);
    end
  endtask

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_wdata = '0;
    void'($urandom(32'd20240611));

    // R2: constant loads, high bits ignored
    fill_nop();
    prog[0] = kc(10'h3FF); prog[1] = kc(10'h000); prog[2] = kc(10'h155);
    prog[3] = 16'h7C00 | 16'h02AA;
    load_and_start();
    run(4, "R2");

    // R3: every ALU function into D
    fill_nop();
    prog[0] = kc(10'd9); prog[1] = ci(1'b0, 4'd4, 3'b010, 3'b000); prog[2] = kc(10'd5);
    for (int f = 0; f < 16; f++) prog[3+f] = ci(1'b0, 4'(f), 3'b010, 3'b000);
    load_and_start();
    run(19, "R3");

    // R4: operand select A vs memory word
    fill_nop();
    prog[0] = kc(10'd3);
    prog[1] = ci(1'b0, 4'd2, 3'b001, 3'b000);
    prog[2] = ci(1'b0, 4'd4, 3'b010, 3'b000);
    prog[3] = ci(1'b1, 4'd4, 3'b010, 3'b000);
    prog[4] = ci(1'b1, 4'd12, 3'b010, 3'b000);
    load_and_start();
    run(5, "R4");

    // R7 read-modify-write, then R5 multi-destination
    fill_nop();
    prog[0] = kc(10'd2);
    prog[1] = ci(1'b1, 4'd10, 3'b001, 3'b000);
    prog[2] = ci(1'b1, 4'd10, 3'b001, 3'b000);
    prog[3] = ci(1'b1, 4'd10, 3'b001, 3'b000);
    prog[4] = ci(1'b1, 4'd4, 3'b010, 3'b000);
    prog[5] = ci(1'b1, 4'd13, 3'b111, 3'b000);
    prog[6] = kc(10'd2);
    prog[7] = ci(1'b1, 4'd4, 3'b010, 3'b000);
    prog[8] = ci(1'b0, 4'd9, 3'b000, 3'b000);
    load_and_start();
    run(5, "R7");
    check("R7", "d after three increments", dbg_d, 3);
    run(4, "R5");
    check("R5", "memory word 2 via d", dbg_d, 6);

    // R6: branch conditions and wrap
    fill_nop();
    prog[0]  = kc(10'd20);
    prog[1]  = ci(1'b0, 4'd3, 3'b000, 3'b010);
    prog[20] = ci(1'b0, 4'd1, 3'b010, 3'b000);
    prog[21] = kc(10'd30);
    prog[22] = ci(1'b0, 4'd3, 3'b000, 3'b100);
    prog[23] = ci(1'b0, 4'd3, 3'b000, 3'b001);
    prog[30] = kc(10'd40);
    prog[31] = ci(1'b0, 4'd2, 3'b010, 3'b011);
    prog[32] = ci(1'b0, 4'd3, 3'b000, 3'b110);
    prog[40] = ci(1'b0, 4'd0, 3'b000, 3'b101);
    prog[41] = kc(10'd63);
    prog[42] = ci(1'b0, 4'd1, 3'b000, 3'b111);
    load_and_start();
    run(14, "R6");
    fill_nop();
    load_and_start();
    run(70, "R6");

    // R8: reserved bits set to ones
    fill_nop();
    prog[0] = kc(10'd7);
    prog[1] = {3'b100, 1'b0, 2'b11, 4'd13, 3'b010, 3'b000};
    prog[2] = {3'b101, 1'b0, 2'b10, 4'd9, 3'b010, 3'b000};
    load_and_start();
    run(3, "R8");
    check("R8", "d after reserved-bit words", dbg_d, 8);

    // R9: reload changes the fetched word
    fill_nop();
    prog[0] = kc(10'd111);
    load_and_start();
    run(1, "R9");
    prog[0] = kc(10'd222);
    load_and_start();
    run(1, "R9");
    check("R9", "a from reloaded word", dbg_a, 222);

    // random programs against the model
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 64; i++) begin
        prog[i] = 16'($urandom);
        if ($urandom_range(0, 2) == 0) prog[i][15] = 1'b0;
      end
      load_and_start();
      run(400, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule